// File: doc/BRIEF.md
# Packet-Driven I2C Master Sequencer

This block turns host-written packets into a stream of byte-level I2C bus commands. The host pushes 32-bit words into a transmit queue: three header words describe one transfer (length, direction, target address, how the transfer ends), and for writes the payload follows, packed four bytes to a word. The sequencer pops the header, asks a separate bit-level engine to raise a start condition, send the address byte, move each data byte and close the transfer. It then waits for a response after every command.

Bytes read from the bus are packed into words and pushed into a receive queue. A sticky status register records successful completion, a missing acknowledge and lost arbitration. Each status bit is cleared by writing a one to it. After an error the sequencer stops and stays stopped until a soft reset. The soft reset empties both queues, clears the status and returns the sequencer to idle.

Top module: `pkt_i2c_seq`

## Requirements
- R1: A transmit word is stored only while the transmit queue has a free slot; otherwise it is dropped. `tx_vacant` reports free transmit slots (FIFO_DEPTH when drained) and `rx_fill` reports stored receive words.
- R2: A packet starts with three header words consumed in order. The first header word has no effect. The second holds the byte count minus one in bits 11:0. In the third, bits 7:1 are the 7-bit target address, bit 19 set selects a read, bit 16 set selects a repeated-start ending, and bit 0 is ignored.
- R3: A transfer issues, in order: start (op 0), the address byte `{address, read flag}` as a write command (op 1), one command per data byte, and finally stop (op 3). No command carries data except address and write bytes.
- R4: On a write, payload bytes are taken lowest lane first from ceil(count/4) words and sent as write commands. The unused upper lanes of the final word never reach the bus.
- R5: On a read, one read command (op 2) is issued per byte, and `cmd_last` is 1 only on the final byte so the engine not-acknowledges it. Received bytes are packed lowest lane first into ceil(count/4) receive words, with unused lanes zero.
- R6: With the repeated-start flag set, the transfer ends with a start command (op 0) instead of stop. The next packet then skips its own opening start.
- R7: Status bit 0 is completion, bit 1 missing acknowledge and bit 2 lost arbitration. Completion is set when the ending command's response arrives. Bits stay set until cleared, and a clear write removes exactly the bits written as one.
- R8: A not-acknowledge on the address byte or on a written byte makes the sequencer issue stop, set bit 1, leave bit 0 clear and halt. A halted sequencer consumes no further transmit words.
- R9: Lost arbitration sets bit 2 and halts at once. No further command is issued and no partial receive word is pushed.
- R10: Soft reset empties both queues, clears status, returns to idle and forgets a pending repeated start, so the next packet begins with a start.
- R11: A command is held stable while `cmd_valid` is high and `cmd_ready` low. Exactly one response is taken per accepted command before the next command is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of queues, status and sequencer |
| tx_wr_en | input | 1 | Push a word into the transmit queue |
| tx_wr_data | input | 32 | Header or payload word |
| tx_vacant | output | $clog2(FIFO_DEPTH+1) | Free transmit slots |
| rx_rd_en | input | 1 | Pop the head receive word |
| rx_rd_data | output | 32 | Head of the receive queue |
| rx_fill | output | $clog2(FIFO_DEPTH+1) | Stored receive words |
| irq_status | output | 3 | Completion, no-acknowledge, arbitration-lost bits |
| irq_clr_en | input | 1 | Apply a clear write to the status |
| irq_clr_mask | input | 3 | Bits to clear |
| cmd_valid | output | 1 | Byte command pending |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| cmd_data | output | 8 | Byte to send |
| cmd_last | output | 1 | Final read byte, answer with not-acknowledge |
| rsp_valid | input | 1 | Engine finished the accepted command |
| rsp_nack | input | 1 | Target did not acknowledge |
| rsp_arb | input | 1 | Arbitration was lost |
| rsp_rdata | input | 8 | Received byte |

## Verification
The bench sweeps byte counts 1 through 9 and 20 in both directions. This covers every final-word fill, so a design that sends the junk upper lanes or leaves stale bytes in a receive word would show up in the command log or the popped words. Repeated-start endings come up mid-sweep, so a sequencer that still opened the next packet with a start, or that forgot the held bus after soft reset, would give a command log one entry off. Errors are injected on the address byte, a middle write byte and a read byte. A design that kept running, reported completion, skipped the closing stop or pushed a partial word would fail these. A backpressured command stretch catches commands that change or repeat under a stalled handshake.

// File: rtl/pkt_i2c_pkg.sv
package pkt_i2c_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  // header field positions
  localparam int HDR_RSTART_BIT = 16;
  localparam int HDR_READ_BIT   = 19;

  // status bit positions
  localparam int IRQ_W    = 3;
  localparam int IRQ_DONE = 0;
  localparam int IRQ_NACK = 1;
  localparam int IRQ_ARB  = 2;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR2, S_HDR3, S_BEGIN, S_ADDR, S_DATA,
    S_FINISH, S_ERRSTOP, S_WAIT, S_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_START, PH_ADDR, PH_DATA, PH_END, PH_ERR
  } seq_phase_e;
endpackage

// File: rtl/pis_fifo.sv
module pis_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign do_wr = wr_en && (cnt != CW'(DEPTH));
  assign do_rd = rd_en && (cnt != '0);

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  assign rd_data = mem[rp];
  assign count   = cnt;
endmodule

// File: rtl/pis_irq.sv
module pis_irq #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] set,
  input  logic         wclr_en,
  input  logic [W-1:0] wclr,
  output logic [W-1:0] status
);
  always_ff @(posedge clk) begin
    if (clr) status <= '0;
    else     status <= (status & ~(wclr_en ? wclr : '0)) | set;
  end
endmodule

// File: rtl/pis_seq.sv
module pis_seq
  import pkt_i2c_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_last,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_arb,
  input  logic [BYTE_W-1:0] rsp_rdata,
  output logic              ev_done,
  output logic              ev_nack,
  output logic              ev_arb
);
  seq_state_e        state;
  seq_phase_e        ph;
  logic [LEN_W-1:0]  len_m1, cnt;
  logic [6:0]        addr_q;
  logic              is_rd, rs, held;
  logic [WORD_W-1:0] wbuf, merged;
  logic [1:0]        lane;
  logic              last_byte, rsp_take;

  function automatic logic [WORD_W-1:0] put_lane(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] ln,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = (ln == 2'd0) ? '0 : w;
    r[{ln, 3'b000} +: BYTE_W] = b;
    return r;
  endfunction

  assign lane      = cnt[1:0];
  assign last_byte = (cnt == len_m1);
  assign rsp_take  = (state == S_WAIT) && !cmd_valid && rsp_valid;
  assign merged    = put_lane(wbuf, lane, rsp_rdata);
  assign rx_data   = merged;
  assign rx_push   = rsp_take && !rsp_arb && (ph == PH_DATA) && is_rd &&
                     ((lane == 2'd3) || last_byte);
  assign ev_arb    = rsp_take && rsp_arb;
  assign ev_nack   = rsp_take && !rsp_arb && rsp_nack &&
                     ((ph == PH_ADDR) || ((ph == PH_DATA) && !is_rd));
  assign ev_done   = rsp_take && !rsp_arb && (ph == PH_END);
  assign tx_pop    = !tx_empty &&
                     ((state inside {S_IDLE, S_HDR2, S_HDR3}) ||
                      ((state == S_DATA) && !is_rd && (lane == 2'd0)));

  always_ff @(posedge clk) begin
    if (clr) begin
      state     <= S_IDLE;
      ph        <= PH_START;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_STOP;
      cmd_data  <= '0;
      cmd_last  <= 1'b0;
      held      <= 1'b0;
      len_m1    <= '0;
      cnt       <= '0;
      addr_q    <= '0;
      is_rd     <= 1'b0;
      rs        <= 1'b0;
      wbuf      <= '0;
    end else begin
      case (state)
        S_IDLE: if (!tx_empty) state <= S_HDR2;
        S_HDR2: if (!tx_empty) begin
          len_m1 <= tx_data[LEN_W-1:0];
          state  <= S_HDR3;
        end
        S_HDR3: if (!tx_empty) begin
          addr_q <= tx_data[7:1];
          is_rd  <= tx_data[HDR_READ_BIT];
          rs     <= tx_data[HDR_RSTART_BIT];
          state  <= S_BEGIN;
        end
        S_BEGIN: begin
          if (held) begin
            held  <= 1'b0;
            state <= S_ADDR;
          end else begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_START;
            cmd_data  <= '0;
            cmd_last  <= 1'b0;
            ph        <= PH_START;
            state     <= S_WAIT;
          end
        end
        S_ADDR: begin
          cmd_valid <= 1'b1;
          cmd_op    <= OP_WRITE;
          cmd_data  <= {addr_q, is_rd};
          cmd_last  <= 1'b0;
          ph        <= PH_ADDR;
          cnt       <= '0;
          state     <= S_WAIT;
        end
        S_DATA: begin
          if (is_rd) begin
            if (!rx_full) begin
              cmd_valid <= 1'b1;
              cmd_op    <= OP_READ;
              cmd_data  <= '0;
              cmd_last  <= last_byte;
              ph        <= PH_DATA;
              state     <= S_WAIT;
            end
          end else if (lane != 2'd0) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_WRITE;
            cmd_data  <= wbuf[{lane, 3'b000} +: BYTE_W];
            cmd_last  <= 1'b0;
            ph        <= PH_DATA;
            state     <= S_WAIT;
          end else if (!tx_empty) begin
            wbuf      <= tx_data;
            cmd_valid <= 1'b1;
            cmd_op    <= OP_WRITE;
            cmd_data  <= tx_data[BYTE_W-1:0];
            cmd_last  <= 1'b0;
            ph        <= PH_DATA;
            state     <= S_WAIT;
          end
        end
        S_FINISH: begin
          cmd_valid <= 1'b1;
          cmd_op    <= rs ? OP_START : OP_STOP;
          cmd_data  <= '0;
          cmd_last  <= 1'b0;
          ph        <= PH_END;
          state     <= S_WAIT;
        end
        S_ERRSTOP: begin
          cmd_valid <= 1'b1;
          cmd_op    <= OP_STOP;
          cmd_data  <= '0;
          cmd_last  <= 1'b0;
          ph        <= PH_ERR;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (cmd_valid) begin
            if (cmd_ready) cmd_valid <= 1'b0;
          end else if (rsp_valid) begin
            if (rsp_arb) begin
              state <= S_HALT;
            end else begin
              case (ph)
                PH_START: state <= S_ADDR;
                PH_ADDR:  state <= rsp_nack ? S_ERRSTOP : S_DATA;
                PH_DATA: begin
                  if (is_rd) wbuf <= merged;
                  if (!is_rd && rsp_nack) state <= S_ERRSTOP;
                  else if (last_byte)     state <= S_FINISH;
                  else begin
                    cnt   <= cnt + 1'b1;
                    state <= S_DATA;
                  end
                end
                PH_END: begin
                  held  <= rs;
                  state <= S_IDLE;
                end
                default: state <= S_HALT;
              endcase
            end
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/pkt_i2c_seq.sv
module pkt_i2c_seq
  import pkt_i2c_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 12,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              tx_wr_en,
  input  logic [31:0]       tx_wr_data,
  output logic [CW-1:0]     tx_vacant,
  input  logic              rx_rd_en,
  output logic [31:0]       rx_rd_data,
  output logic [CW-1:0]     rx_fill,
  output logic [2:0]        irq_status,
  input  logic              irq_clr_en,
  input  logic [2:0]        irq_clr_mask,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_data,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_arb,
  input  logic [7:0]        rsp_rdata
);
  logic              clr;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tx_pop, rx_push;
  logic              ev_done, ev_nack, ev_arb;
  logic [IRQ_W-1:0]  ev_vec;

  assign clr = rst || soft_rst;

  pis_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .clr(clr), .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(tx_pop), .rd_data(tx_head), .count(tx_count)
  );

  pis_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .clr(clr), .wr_en(rx_push), .wr_data(rx_word),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data), .count(rx_count)
  );

  pis_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .clr(clr),
    .tx_data(tx_head), .tx_empty(tx_count == '0),
    .rx_full(rx_count == CW'(FIFO_DEPTH)),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb),
    .rsp_rdata(rsp_rdata),
    .ev_done(ev_done), .ev_nack(ev_nack), .ev_arb(ev_arb)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[IRQ_DONE] = ev_done;
    ev_vec[IRQ_NACK] = ev_nack;
    ev_vec[IRQ_ARB]  = ev_arb;
  end

  pis_irq #(.W(IRQ_W)) u_irq (
    .clk(clk), .clr(clr), .set(ev_vec),
    .wclr_en(irq_clr_en), .wclr(irq_clr_mask), .status(irq_status)
  );

  assign tx_vacant = CW'(FIFO_DEPTH) - tx_count;
  assign rx_fill   = rx_count;
endmodule

// File: rtl/pkt_i2c_seq_chk.sv
module pkt_i2c_seq_chk #(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic [CW-1:0] tx_vacant,
  input logic [CW-1:0] rx_fill,
  input logic [2:0]    irq_status,
  input logic          irq_clr_en,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_data,
  input logic          cmd_last
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (tx_vacant <= CW'(FIFO_DEPTH)) && (rx_fill <= CW'(FIFO_DEPTH))); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst || soft_rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
                                $stable(cmd_data) && $stable(cmd_last)); // R11

  AST_LAST_ON_READ: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_last |-> cmd_op == 2'd2); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !irq_clr_en |=> (irq_status & $past(irq_status)) == $past(irq_status)); // R7

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> irq_status == 3'd0 && tx_vacant == CW'(FIFO_DEPTH) &&
                 rx_fill == '0 && !cmd_valid); // R10
endmodule

bind pkt_i2c_seq pkt_i2c_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .tx_vacant(tx_vacant),
  .rx_fill(rx_fill), .irq_status(irq_status), .irq_clr_en(irq_clr_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .cmd_last(cmd_last)
);

// File: tb/pkt_i2c_seq_tb.sv
module pkt_i2c_seq_tb;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0;
  logic tx_wr_en = 1'b0;
  logic [31:0] tx_wr_data = '0;
  logic [CW-1:0] tx_vacant, rx_fill;
  logic rx_rd_en = 1'b0;
  logic [31:0] rx_rd_data;
  logic [2:0] irq_status;
  logic irq_clr_en = 1'b0;
  logic [2:0] irq_clr_mask = '0;
  logic cmd_valid, cmd_last;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic cmd_ready, rsp_valid, rsp_nack, rsp_arb;
  logic [7:0] rsp_rdata;

  int checks = 0, errors = 0;
  int log_n = 0, exp_n = 0, rd_idx = 0, cyc = 0;
  int nack_at = -1, arb_at = -1;
  bit stall_mode = 1'b0, pend = 1'b0, p_nack, p_arb;
  logic [7:0] p_data;
  logic [10:0] log_q [64];
  logic [10:0] exp_q [64];

  always #10 clk = ~clk;

  pkt_i2c_seq #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_vacant(tx_vacant),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_fill(rx_fill),
    .irq_status(irq_status), .irq_clr_en(irq_clr_en), .irq_clr_mask(irq_clr_mask),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb),
    .rsp_rdata(rsp_rdata)
  );

  function automatic logic [7:0] wbyte(input int n, input int i);
    return 8'((i * 37 + n * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] rbyte(input int i);
    return 8'((i * 53 + 33) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit-level engine model: logs commands, answers one cycle later
  initial begin
    cmd_ready = 1'b1; rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_arb = 1'b0; rsp_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_arb = 1'b0;
      if (pend) begin
        rsp_valid = 1'b1; rsp_nack = p_nack; rsp_arb = p_arb; rsp_rdata = p_data;
        pend = 1'b0;
      end
      cmd_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      if (cmd_valid && cmd_ready) begin
        if (log_n < 64) log_q[log_n] = {cmd_op, cmd_last, cmd_data};
        p_nack = (log_n == nack_at);
        p_arb  = (log_n == arb_at);
        p_data = 8'h00;
        if (cmd_op == 2'd2) begin
          p_data = rbyte(rd_idx);
          rd_idx++;
        end
        log_n++;
        pend = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic push(input logic [31:0] w);
    tx_wr_en = 1'b1; tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic send_pkt(input bit rd, input int n, input logic [6:0] a,
                          input bit rs, input logic [31:0] h1);
    logic [31:0] h3, w;
    log_n = 0; rd_idx = 0;
    h3 = '0;
    h3[7:0] = {a, ~rd};
    h3[19] = rd;
    h3[16] = rs;
    push(h1);
    push(32'(n - 1));
    push(h3);
    if (!rd) begin
      for (int j = 0; j < (n + 3) / 4; j++) begin
        for (int b = 0; b < 4; b++)
          w[b*8 +: 8] = (4*j + b < n) ? wbyte(n, 4*j + b) : 8'hA5;
        push(w);
      end
    end
  endtask

  task automatic add_exp(input logic [1:0] op, input bit last, input logic [7:0] d);
    exp_q[exp_n] = {op, last, d};
    exp_n++;
  endtask

  task automatic build_exp(input bit rd, input int n, input logic [6:0] a,
                           input bit rs, input bit held);
    exp_n = 0;
    if (!held) add_exp(2'd0, 1'b0, 8'h00);
    add_exp(2'd1, 1'b0, {a, rd});
    for (int i = 0; i < n; i++) begin
      if (rd) add_exp(2'd2, i == n - 1, 8'h00);
      else    add_exp(2'd1, 1'b0, wbyte(n, i));
    end
    add_exp(rs ? 2'd0 : 2'd3, 1'b0, 8'h00);
  endtask

  task automatic cmp_log(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && i < 64 && log_q[i] !== exp_q[i]) bad = i;
    check(log_n == exp_n && bad < 0, req, "bus command sequence",
          bad < 0 ? log_n : log_q[bad], bad < 0 ? exp_n : exp_q[bad]);
  endtask

  task automatic wait_status;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq_status != 3'd0) break;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_status(input logic [2:0] m);
    irq_clr_en = 1'b1; irq_clr_mask = m;
    @(negedge clk);
    irq_clr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_soft_reset;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_ok(input bit rd, input int n, input logic [6:0] a,
                        input bit rs, input bit held, input logic [31:0] h1);
    logic [31:0] ew;
    send_pkt(rd, n, a, rs, h1);
    wait_status();
    build_exp(rd, n, a, rs, held);
    if (rd) cmp_log("R5");
    else if (rs || held) cmp_log("R6");
    else cmp_log("R3");
    check(irq_status == 3'b001, "R7", "completion status", irq_status, 1);
    if (rd) begin
      check(rx_fill == CW'((n + 3) / 4), "R5", "receive word count", rx_fill, (n + 3) / 4);
      for (int j = 0; j < (n + 3) / 4; j++) begin
        for (int b = 0; b < 4; b++)
          ew[b*8 +: 8] = (4*j + b < n) ? rbyte(4*j + b) : 8'h00;
        check(rx_rd_data == ew, "R5", "packed receive word", rx_rd_data, ew);
        rx_rd_en = 1'b1;
        @(negedge clk);
        rx_rd_en = 1'b0;
      end
    end else begin
      check(tx_vacant == CW'(DEPTH), "R4", "payload words consumed", tx_vacant, DEPTH);
    end
    clear_status(3'b001);
    check(irq_status == 3'b000, "R7", "clear write", irq_status, 0);
  endtask

  initial begin
    bit held;
    bit rs;
    int n;
    repeat (5) @(negedge clk);
    check(tx_vacant == CW'(DEPTH) && rx_fill == '0, "R1", "reset fill counts", {tx_vacant, rx_fill}, DEPTH << CW);
    check(irq_status == 3'd0 && !cmd_valid, "R10", "reset status and command", {irq_status, cmd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep lengths and directions; first header word varied, R2
    held = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      n = (k == 10) ? 20 : k;
      for (int rd = 0; rd < 2; rd++) begin
        rs = ((k + rd) % 3 == 0);
        stall_mode = (k == 5);
        run_ok(rd[0], n, 7'(7'h15 + k * 3 + rd), rs, held, 32'(k * 32'h1357_9BDF));
        held = rs;
      end
    end
    stall_mode = 1'b0;

    // address not acknowledged, R8
    do_soft_reset();
    nack_at = 1;
    send_pkt(1'b0, 6, 7'h2A, 1'b0, 32'h0);
    wait_status();
    build_exp(1'b0, 6, 7'h2A, 1'b0, 1'b0);
    exp_n = 2;
    add_exp(2'd3, 1'b0, 8'h00);
    cmp_log("R8");
    check(irq_status == 3'b010, "R8", "no-ack status without completion", irq_status, 2);
    check(tx_vacant == CW'(DEPTH - 2), "R8", "payload left untouched", tx_vacant, DEPTH - 2);
    nack_at = -1;
    log_n = 0;
    push(32'h0); push(32'h0); push(32'h0000_0040);
    repeat (30) @(negedge clk);
    check(tx_vacant == CW'(DEPTH - 5) && log_n == 0, "R8", "halted sequencer idle", {tx_vacant, 8'(log_n)}, (DEPTH - 5) << 8);
    clear_status(3'b101);
    check(irq_status == 3'b010, "R7", "clear of unset bits", irq_status, 2);
    clear_status(3'b010);
    check(irq_status == 3'b000, "R7", "clear of no-ack bit", irq_status, 0);

    do_soft_reset();
    check(tx_vacant == CW'(DEPTH) && irq_status == 3'd0, "R10", "soft reset empties queue", tx_vacant, DEPTH);

    // write byte not acknowledged, R8
    nack_at = 3;
    send_pkt(1'b0, 5, 7'h33, 1'b0, 32'h0);
    wait_status();
    build_exp(1'b0, 5, 7'h33, 1'b0, 1'b0);
    exp_n = 4;
    add_exp(2'd3, 1'b0, 8'h00);
    cmp_log("R8");
    check(irq_status == 3'b010, "R8", "no-ack on data byte", irq_status, 2);
    nack_at = -1;

    // arbitration lost during a read, R9
    do_soft_reset();
    arb_at = 2;
    send_pkt(1'b1, 4, 7'h51, 1'b0, 32'h0);
    wait_status();
    build_exp(1'b1, 4, 7'h51, 1'b0, 1'b0);
    exp_n = 3;
    cmp_log("R9");
    check(irq_status == 3'b100, "R9", "arbitration status", irq_status, 4);
    check(rx_fill == '0, "R9", "no partial receive word", rx_fill, 0);
    arb_at = -1;
    repeat (20) @(negedge clk);
    check(log_n == 3, "R9", "no command after loss", log_n, 3);

    // queue overflow while halted, R1
    for (int i = 0; i < 10; i++) push(32'(i));
    check(tx_vacant == '0, "R1", "full queue drops extra words", tx_vacant, 0);
    do_soft_reset();
    check(tx_vacant == CW'(DEPTH) && irq_status == 3'd0, "R10", "soft reset after halt", {tx_vacant, irq_status}, DEPTH << 3);

    // repeated start forgotten by soft reset, R10
    run_ok(1'b0, 2, 7'h0C, 1'b1, 1'b0, 32'h0);
    do_soft_reset();
    send_pkt(1'b0, 2, 7'h0C, 1'b0, 32'h0);
    wait_status();
    build_exp(1'b0, 2, 7'h0C, 1'b0, 1'b0);
    cmp_log("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule